// File: doc/BRIEF.md
# SYSREF Divider Alignment Monitor

This block watches a SYSREF input and compares each of its rising edges against a free-running divide-by-DIV clock divider, with DIV defaulting to 16. SYSREF is first brought into the divider clock domain. Each rising edge that survives the enable gating is then classed in one of two ways. It is consistent when the divider count is 0 on the cycle the edge is seen. It is inconsistent otherwise.

When realignment is enabled, an inconsistent edge restarts the divider so that the edge cycle becomes phase 0. The block records three sticky events that software clears by writing 1: an edge was seen, the divider was realigned, and an associated clock was realigned. It also keeps a read-only flag that reports whether recent edges agreed with the divider.

Software reaches the control bits and the status flags through a small register port. Writes are synchronous. Reads are combinational and return the register at the current address.

Top module: `sysref_div_monitor`

## Requirements
- R1: After reset the divider count is 0, and both the control register (address 0) and the status register (address 1) read 0.
- R2: The divider count steps by 1 on every clock and wraps from DIV-1 to 0. `div_tick` is high while the count equals DIV-1.
- R3: A rising edge on `sysref_in` is seen as an edge two clocks after it is sampled. The status flags show the result one clock after that.
- R4: Status bit 0 (edge seen) sets on every accepted edge and stays set until software writes 1 to it.
- R5: With control bit 0 (realign enable) set, an edge seen while the count is not 0 makes the count read 1 on the next cycle. It also sets status bit 1 (divider realigned) and status bit 2 (clock realigned).
- R6: With realign enable clear, an edge never changes the divider sequence and never sets status bits 1 or 2.
- R7: Status bit 3 (aligned) is updated on every accepted edge, whatever the state of realign enable. It reads 1 only after two consecutive edges that both found the count at 0. An edge with a nonzero count clears it.
- R8: Edges are accepted only while control bit 1 (receiver enable) and control bit 2 (processor enable) are both set. Any other edge changes no flag and does not touch the divider.
- R9: A write to the status register clears exactly those of bits 0 to 2 that are written as 1. Bit 3 ignores writes. When a set event and a clear fall on the same cycle, the flag ends up set.
- R10: Control bits 2:0 read back as written at address 0. Addresses other than 0 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sysref_in | input | 1 | Asynchronous SYSREF level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| div_phase | output | CW | Current divider count |
| div_tick | output | 1 | High on the divider's terminal count |

## Verification
The bench drives SYSREF on a falling clock edge, then samples on later falling edges.

One clock after the drive, the level sits in the first synchronizer flop. Two clocks after, the edge is live, and the bench reads the divider count and the still-clear status at that point. Three clocks after, the count is checked to have either stepped or been reloaded to 1, and the new status flags are read.

To hit a chosen edge phase, the bench waits for the count to read two less than that phase before raising SYSREF. For the write-clear collision, the write strobe is raised during the edge cycle so that it lands on the same clock edge as the flag update.

// File: rtl/sysref_div_monitor.sv
module sysref_div_monitor #(
  parameter int DIV = 16,
  parameter int AW  = 2,
  parameter int DW  = 8,
  parameter int CW  = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sysref_in,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [CW-1:0] div_phase,
  output logic          div_tick
);

  localparam logic [AW-1:0] ADDR_CTRL = AW'(0);
  localparam logic [AW-1:0] ADDR_STAT = AW'(1);
  localparam logic [CW-1:0] LAST      = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [2:0]    sync_q;
  logic          align_q, rx_q, proc_q;
  logic          det_q, div_re_q, clk_re_q, aligned_q, prev_ok_q;
  logic          edge_ok, consistent, realign, wr_ctrl, wr_stat;

  assign edge_ok    = sync_q[1] & ~sync_q[2] & rx_q & proc_q;
  assign consistent = (cnt_q == '0);
  assign realign    = edge_ok & align_q & ~consistent;
  assign wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_stat    = reg_wr && (reg_addr == ADDR_STAT);

  assign div_phase  = cnt_q;
  assign div_tick   = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], sysref_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (realign)    cnt_q <= CW'(1);
    else if (div_tick)   cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_q <= 1'b0;
      rx_q    <= 1'b0;
      proc_q  <= 1'b0;
    end else if (wr_ctrl) begin
      align_q <= reg_wdata[0];
      rx_q    <= reg_wdata[1];
      proc_q  <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q    <= 1'b0;
      div_re_q <= 1'b0;
      clk_re_q <= 1'b0;
    end else begin
      det_q    <= edge_ok | (det_q    & ~(wr_stat & reg_wdata[0]));
      div_re_q <= realign | (div_re_q & ~(wr_stat & reg_wdata[1]));
      clk_re_q <= realign | (clk_re_q & ~(wr_stat & reg_wdata[2]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
      prev_ok_q <= 1'b0;
    end else if (edge_ok) begin
      aligned_q <= consistent & prev_ok_q;
      prev_ok_q <= consistent;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: reg_rdata[2:0] = {proc_q, rx_q, align_q};
      ADDR_STAT: reg_rdata[3:0] = {aligned_q, clk_re_q, div_re_q, det_q};
      default:   reg_rdata = '0;
    endcase
  end

  a_r6_free_run_without_realign: assert property (@(posedge clk) disable iff (!rst_n)
    !align_q |=> (cnt_q == (($past(cnt_q) == LAST) ? '0 : CW'($past(cnt_q) + 1'b1))));

  a_r5_realign_loads_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ok && align_q && cnt_q != '0) |=> (cnt_q == CW'(1) && div_re_q && clk_re_q));

  a_r6_realign_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_re_q) |-> $past(align_q));

  a_r4_edge_sets_detect: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ok |=> det_q);

  a_r7_aligned_needs_zero_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned_q) |-> $past(edge_ok && cnt_q == '0));

  a_r8_detect_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_q) |-> $past(rx_q && proc_q));

endmodule

// File: tb/sysref_div_monitor_bench.sv
module sysref_div_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sysref_in = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [3:0] div_phase;
  logic       div_tick;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysref_div_monitor u_sysref_div_monitor (
    .clk(clk), .rst_n(rst_n), .sysref_in(sysref_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .div_phase(div_phase), .div_tick(div_tick));

  // {align_en, edge phase, exp aligned, exp realigned, exp count after}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 4'd5,  1'b0, 1'b0, 4'd6},
    {1'b0, 4'd0,  1'b0, 1'b0, 4'd1},
    {1'b0, 4'd0,  1'b1, 1'b0, 4'd1},
    {1'b1, 4'd0,  1'b1, 1'b0, 4'd1},
    {1'b1, 4'd9,  1'b0, 1'b1, 4'd1},
    {1'b1, 4'd0,  1'b0, 1'b0, 4'd1},
    {1'b1, 4'd0,  1'b1, 1'b0, 4'd1},
    {1'b0, 4'd15, 1'b0, 1'b0, 4'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [3:0] ph, input bit clr_same,
                       output logic [3:0] c_edge, output logic [3:0] c_after,
                       output logic [7:0] s_edge, output logic [7:0] s_after);
    @(negedge clk);
    while (div_phase != ph - 4'd2) @(negedge clk);
    sysref_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    c_edge = div_phase;
    rd(2'd1, s_edge);
    if (clr_same) begin reg_wdata = 8'h07; reg_wr = 1'b1; end
    @(negedge clk);
    reg_wr = 1'b0;
    c_after = div_phase;
    rd(2'd1, s_after);
    sysref_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, s_e, s_a;
    logic [3:0] c_e, c_a, prev;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", div_phase, 0);
    rd(2'd0, s); chk("R1 ctrl reset", s, 0);
    rd(2'd1, s); chk("R1 status reset", s, 0);
    rst_n = 1'b1;

    @(negedge clk);
    prev = div_phase;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R2 count step", div_phase, 4'(prev + 4'd1));
      chk("R2 tick", div_tick, (div_phase == 4'd15));
      prev = div_phase;
    end

    pulse(4'd3, 1'b0, c_e, c_a, s_e, s_a);
    chk("R8 ignored when disabled", s_a, 0);
    wr(2'd0, 8'h04);
    pulse(4'd3, 1'b0, c_e, c_a, s_e, s_a);
    chk("R8 ignored without rx", s_a, 0);
    wr(2'd0, 8'h03);
    pulse(4'd7, 1'b0, c_e, c_a, s_e, s_a);
    chk("R8 ignored without proc", s_a, 0);
    chk("R8 no realign without proc", c_a, 8);

    wr(2'd0, 8'h05);
    rd(2'd0, s); chk("R10 ctrl readback", s, 8'h05);
    rd(2'd2, s); chk("R10 unmapped addr", s, 0);

    for (int v = 0; v < 8; v++) begin
      wr(2'd0, {5'd0, 2'b11, VEC[v][10]});
      wr(2'd1, 8'h07);
      pulse(VEC[v][9:6], 1'b0, c_e, c_a, s_e, s_a);
      chk("R2 phase at edge", c_e, VEC[v][9:6]);
      chk("R3 detect not yet set", s_e[0], 0);
      chk("R4 detect set", s_a[0], 1);
      chk("R5 R6 divider realigned flag", s_a[1], VEC[v][4]);
      chk("R5 R6 clock realigned flag", s_a[2], VEC[v][4]);
      chk("R7 aligned flag", s_a[3], VEC[v][5]);
      chk("R5 R6 count after edge", c_a, VEC[v][3:0]);
    end

    wr(2'd1, 8'h00);
    rd(2'd1, s); chk("R9 write 0 keeps detect", s[0], 1);
    wr(2'd1, 8'h01);
    rd(2'd1, s); chk("R4 detect cleared by write 1", s[0], 0);

    wr(2'd0, 8'h06);
    pulse(4'd0, 1'b0, c_e, c_a, s_e, s_a);
    pulse(4'd0, 1'b0, c_e, c_a, s_e, s_a);
    chk("R7 aligned after two good edges", s_a[3], 1);
    wr(2'd1, 8'hFF);
    rd(2'd1, s); chk("R9 aligned ignores write", s, 8'h08);
    pulse(4'd0, 1'b1, c_e, c_a, s_e, s_a);
    chk("R9 set wins over clear", s_a, 8'h09);
    wr(2'd0, 8'h07);
    wr(2'd1, 8'h07);
    pulse(4'd4, 1'b1, c_e, c_a, s_e, s_a);
    chk("R9 realign set wins over clear", s_a, 8'h07);
    chk("R5 count reloaded", c_a, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule